// File: doc/BRIEF.md
# Programmable Output Clock Divider

This block turns a source clock into a slower output clock by dividing it by a whole number between 2 and 20. The high and low parts of the output stay as close to equal as the source clock's two edges allow. Even ratios come out at exactly half high. Odd ratios add a stage clocked on the falling edge, which stretches the high phase by half a source cycle, so the output is high for exactly half of its period as well.

A bypass select sends the raw reference clock straight to the output instead of the divided clock. This is the state used before the divider has been programmed. An active-low power-down input turns off the output enable, parks the output low and holds the divider at the start of a period, so the output restarts cleanly when power-down is released. A new ratio is taken only at the end of the output period in progress, so reprogramming never cuts a period short.

Top module: `prog_clk_div`

## Requirements
- R1: `div_ratio` is a 5-bit unsigned value. Values 0 and 1 act as ratio 2, values 21 to 31 act as ratio 20, and values 2 to 20 are used as given.
- R2: With bypass low and power-down inactive, each output period lasts exactly D source-clock cycles, where D is the effective ratio.
- R3: For even D, each period begins with D/2 low source cycles, followed by D/2 high source cycles.
- R4: For odd D, the output is high for exactly D source half-cycles of every period, which is a 50% duty cycle.
- R5: A change on `div_ratio` does not alter the period in progress. The new ratio starts with the next period, beginning with that period's low phase.
- R6: While `bypass` is high and `pd_n` is high, `clk_o` follows `ref_clk` with no clock delay.
- R7: While `pd_n` is low, `clk_oe` is 0 and `clk_o` is 0 whatever `bypass` and `ref_clk` are, and the divider is held at the start of a period. While `pd_n` is high, `clk_oe` is 1.
- R8: While `rst_n` is low, `clk_o` is low. After `rst_n` or `pd_n` is released (sampled high at a rising source edge), the output stays low for D - floor(D/2) source cycles, counted from the start of the first cycle after release, before it first rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock to be divided |
| ref_clk | input | 1 | Reference clock, used in bypass |
| rst_n | input | 1 | Synchronous active-low reset |
| div_ratio | input | 5 | Requested divide ratio, clamped to 2..20 |
| bypass | input | 1 | 1 sends ref_clk to the output |
| pd_n | input | 1 | Active-low power-down |
| clk_o | output | 1 | Output clock value |
| clk_oe | output | 1 | Output enable; 0 means the pin floats |

## Verification
The hardest situation to reach from the ports is a ratio change that lands in the middle of an output period. A wrong design that loads the ratio at once looks correct unless the change arrives after the period's rising edge but before its end. The bench locks onto a rising output transition and changes the ratio in that same half-cycle. It then measures the rest of the old high phase and the length of the first new low phase. Odd-ratio duty is checked by sampling after every edge of the source clock, both rising and falling, so the extra half cycle is seen directly.

// File: rtl/divr_pkg.sv
// Package: shared defaults for the programmable clock divider.
// Assumes: ratio limits fit in DIV_W bits.
package divr_pkg;
    localparam int unsigned DIV_W  = 5;
    localparam int unsigned DIV_LO = 2;
    localparam int unsigned DIV_HI = 20;
endpackage

// File: rtl/divr_ratio_reg.sv
// Module: holds the effective ratio. It clamps the request into [LO, HI] and
// loads it only at a period boundary or while the divider is held.
// Assumes: load_i comes high in the cycle in which the counter wraps.
module divr_ratio_reg #(
    parameter int unsigned W  = divr_pkg::DIV_W,
    parameter int unsigned LO = divr_pkg::DIV_LO,
    parameter int unsigned HI = divr_pkg::DIV_HI
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_i,
    input  logic         load_i,
    output logic [W-1:0] ratio_o
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    logic [W-1:0] clamped;

    // Clamp the requested ratio to the legal range.
    always_comb begin
        if (req_i < LO_V)      clamped = LO_V;
        else if (req_i > HI_V) clamped = HI_V;
        else                   clamped = req_i;
    end

    // Take the clamped request during reset or at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) ratio_o <= clamped;
    end

    p_ratio_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_o >= LO_V) && (ratio_o <= HI_V));

    p_ratio_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(ratio_o));
endmodule

// File: rtl/divr_phase_cnt.sv
// Module: rising-edge period counter. Each period has a low phase of
// ratio - floor(ratio/2) cycles, then a high phase of floor(ratio/2) cycles.
// Assumes: ratio_i >= 2 and ratio_i changes only at the wrap edge.
module divr_phase_cnt #(
    parameter int unsigned W = divr_pkg::DIV_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] ratio_i,
    output logic         pos_o,
    output logic         load_o
);
    logic [W-1:0] cnt;
    logic [W-1:0] cnt_inc;
    logic [W-1:0] rise_at;
    logic         wrap;

    assign cnt_inc = cnt + W'(1);
    assign rise_at = ratio_i - (ratio_i >> 1);
    assign wrap    = (cnt == ratio_i - W'(1));
    assign load_o  = wrap | ~run_i;

    // Advance the count and register the high phase aligned to it.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt   <= '0;
            pos_o <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            pos_o <= 1'b0;
        end else begin
            cnt   <= cnt_inc;
            pos_o <= (cnt_inc >= rise_at);
        end
    end

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < ratio_i);

    p_low_after_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> !pos_o);

    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!pos_o && cnt == '0));
endmodule

// File: rtl/divr_half_ext.sv
// Module: falling-edge copy of the high phase. It is ORed in for odd ratios
// so the high phase gains half a source cycle.
// Assumes: odd_i changes only on rising edges.
module divr_half_ext (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic odd_i,
    input  logic pos_i,
    output logic clk_div_o
);
    logic neg_q;

    // Capture the high phase half a cycle late, only for odd ratios.
    always_ff @(negedge clk) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= pos_i & odd_i & run_i;
    end

    assign clk_div_o = pos_i | neg_q;

    p_ext_odd_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        neg_q |-> odd_i);
endmodule

// File: rtl/prog_clk_div.sv
// Module: top of the programmable output divider. It holds the ratio, the
// period counter and the odd-ratio stage, then selects bypass and gates
// power-down.
// Assumes: clk_src is the divider's only clock; ref_clk is used only as data
// through the bypass select.
module prog_clk_div #(
    parameter int unsigned W  = divr_pkg::DIV_W,
    parameter int unsigned LO = divr_pkg::DIV_LO,
    parameter int unsigned HI = divr_pkg::DIV_HI
) (
    input  logic         clk_src,
    input  logic         ref_clk,
    input  logic         rst_n,
    input  logic [W-1:0] div_ratio,
    input  logic         bypass,
    input  logic         pd_n,
    output logic         clk_o,
    output logic         clk_oe
);
    logic [W-1:0] ratio;
    logic         pos_q;
    logic         load;
    logic         clk_div;

    divr_ratio_reg #(.W(W), .LO(LO), .HI(HI)) i_ratio (
        .clk(clk_src), .rst_n(rst_n), .req_i(div_ratio),
        .load_i(load), .ratio_o(ratio)
    );

    divr_phase_cnt #(.W(W)) i_cnt (
        .clk(clk_src), .rst_n(rst_n), .run_i(pd_n), .ratio_i(ratio),
        .pos_o(pos_q), .load_o(load)
    );

    divr_half_ext i_ext (
        .clk(clk_src), .rst_n(rst_n), .run_i(pd_n), .odd_i(ratio[0]),
        .pos_i(pos_q), .clk_div_o(clk_div)
    );

    // Select the output source and gate it with power-down.
    always_comb begin
        clk_oe = pd_n;
        clk_o  = pd_n & (bypass ? ref_clk : clk_div);
    end
endmodule

// File: tb/test_prog_clk_div.sv
module test_prog_clk_div;
    logic       clk_src = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [4:0] div_ratio = 5'd7;
    logic       bypass  = 1'b0;
    logic       pd_n    = 1'b1;
    logic       clk_o, clk_oe;
    int n_cmp = 0;
    int n_bad = 0;

    prog_clk_div i_prog_clk_div (
        .clk_src(clk_src), .ref_clk(ref_clk), .rst_n(rst_n),
        .div_ratio(div_ratio), .bypass(bypass), .pd_n(pd_n),
        .clk_o(clk_o), .clk_oe(clk_oe)
    );

    always #5 clk_src = ~clk_src;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Sample 2 ns after the next edge of either polarity.
    task automatic next_half(output logic v);
        @(posedge clk_src or negedge clk_src);
        #2;
        v = clk_o;
    endtask

    task automatic after_rise;
        @(posedge clk_src);
        #2;
    endtask

    // From the present sample, find a 0->1 transition, then measure one period in half-cycles.
    task automatic measure(output int per, output int hi);
        logic prev, v;
        prev = clk_o;
        per = 0; hi = 0;
        for (int g = 0; g < 200; g++) begin
            next_half(v);
            if (!prev && v) break;
            prev = v;
        end
        per = 1; hi = 1; prev = 1'b1;
        for (int g = 0; g < 200; g++) begin
            next_half(v);
            if (!prev && v) break;
            per++; hi += int'(v); prev = v;
        end
    endtask

    function automatic int eff(input int r);
        return (r < 2) ? 2 : ((r > 20) ? 20 : r);
    endfunction

    task automatic count_low_until_high(output int n);
        logic v;
        n = 0;
        for (int g = 0; g < 200; g++) begin
            next_half(v);
            if (v) break;
            n++;
        end
    endtask

    initial begin
        int per, hi, n, d;
        logic v;
        // Reset state (R8, R7)
        repeat (3) next_half(v);
        chk("R8 low in reset", int'(clk_o), 0);
        chk("R7 oe on", int'(clk_oe), 1);
        after_rise();
        rst_n = 1'b1;
        count_low_until_high(n);
        chk("R8 first low after reset", n, 2*(7 - 7/2) - 1);

        // Sweep of all 5-bit ratio values (R1, R2, R3, R4)
        for (int r = 0; r < 32; r++) begin
            div_ratio = 5'(r);
            d = eff(r);
            measure(per, hi);
            measure(per, hi);
            if (r < 2 || r > 20) chk("R1 clamped period", per, 2*d);
            else                 chk("R2 period", per, 2*d);
            if (d % 2 == 1) chk("R4 odd high half-cycles", hi, d);
            else            chk("R3 even high half-cycles", hi, d);
        end

        // Ratio change in the middle of a period (R5)
        div_ratio = 5'd4;
        measure(per, hi);
        measure(per, hi);
        div_ratio = 5'd10;
        n = 1;
        for (int g = 0; g < 100; g++) begin
            next_half(v);
            if (!v) break;
            n++;
        end
        chk("R5 old high phase kept", n, 4);
        n = 1;
        for (int g = 0; g < 100; g++) begin
            next_half(v);
            if (v) break;
            n++;
        end
        chk("R5 new low phase", n, 10);

        // Bypass (R6)
        bypass = 1'b1;
        for (int k = 0; k < 6; k++) begin
            ref_clk = k[0];
            #1;
            chk("R6 bypass follows ref", int'(clk_o), k[0]);
            #3;
        end

        // Power-down (R7)
        div_ratio = 5'd5;
        after_rise();
        pd_n = 1'b0;
        for (int k = 0; k < 6; k++) begin
            ref_clk = 1'b1;
            #1;
            chk("R7 oe off", int'(clk_oe), 0);
            chk("R7 out low", int'(clk_o), 0);
            next_half(v);
        end
        bypass = 1'b0;
        ref_clk = 1'b0;
        after_rise();
        pd_n = 1'b1;
        #1;
        chk("R7 oe back", int'(clk_oe), 1);
        count_low_until_high(n);
        chk("R7 restart low phase", n, 2*(5 - 5/2) - 1);
        measure(per, hi);
        chk("R7 period after restart", per, 10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule